// File: doc/BRIEF.md
# SPI Status Response Word Builder

This block supplies the 16-bit reply that a serial-peripheral slave sends back during each transfer. When chip select goes active it takes a snapshot of a word built from live status inputs. It then shifts that word out most significant bit first, one bit for each serial clock. At the same time it collects the incoming frame. When a frame of exactly sixteen clocks closes, it keeps that frame's leading bit, the watchdog toggle bit. That kept bit is the first bit of the next reply. It also selects which of two status sources feeds each of the three bits that follow it, so every reply depends on the transfer before it.

The serial pins are asynchronous to the block clock. They are oversampled through a synchronizer and edge detectors, so all state lives in the block clock domain. The status inputs (direct-input levels, the fail-safe strap level, the wake-up level and the twelve fault flags) are assumed to be synchronous to that clock. The kept watchdog bit is also brought out as a plain output for the watchdog logic nearby. The data path is a bit-serial pin interface with no valid/ready pair. The master paces it through select and clock, so no back-pressure exists.

Top module: `spi_status_word`

## Requirements
- R1: After reset, `wd_echo` is 0 and `sdo` is 0.
- R2: While the block is deselected, `sdo` is 0, including right after select returns high.
- R3: Reply bit 15 (sent first) equals `wd_echo` as it stood when select fell. The word is sent MSB first, one new bit after each falling `sck` edge.
- R4: With bit 15 = 0, bit 14 = `dir_in[0]` and bit 13 = `dir_in[1]`. With bit 15 = 1, bit 14 = `dir_in[2]` and bit 13 = `dir_in[3]`.
- R5: Bit 12 carries `failsafe_en` when bit 15 is 0 and `wkup_lvl` when bit 15 is 1.
- R6: Bits 11..4 carry `ls_flt[7:0]` (bit 11 = `ls_flt[7]`). Bits 3..0 carry `hs_flt[3:0]` (bit 3 = `hs_flt[3]`).
- R7: `wd_echo` takes the first bit received (`sdi` sampled at the first rising `sck`) only when select rises after exactly 16 rising `sck` edges. Shorter or longer frames leave it unchanged.
- R8: The reply is sampled once, when select falls. Status input changes during the frame do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from master |
| sdo | output | 1 | Serial reply data, 0 when deselected |
| wd_echo | output | 1 | Watchdog bit kept from the last complete frame |
| dir_in | input | 4 | Direct-input levels |
| failsafe_en | input | 1 | Fail-safe enable strap level |
| wkup_lvl | input | 1 | Wake-up input level |
| ls_flt | input | 8 | Low-side fault flags, index 0 = lowest channel |
| hs_flt | input | 4 | High-side fault flags |

## Verification
Each serial pin edge is acted on on the third block clock edge after it changes: two synchronizer stages plus one edge-detect register. So the first reply bit appears three clocks after select falls. Each later bit appears three clocks after the falling `sck` edge, and `wd_echo` commits three clocks after select rises. The bench holds every `sck` phase and select change for four or more clocks and samples on the falling clock edge after that wait, so every result has settled before it is read. Frame-to-frame effects are checked by chaining table vectors, where each vector's expected bit 15 and mux selection come from the previous vector's transmitted word.

// File: rtl/sst_pkg.sv
package sst_pkg;
  // Bits above the fault flags: echo, two direct-input slots, strap/wake slot
  localparam int CTRL_BITS = 4;
  localparam int N_DIR     = 4;

  typedef struct packed {
    logic [N_DIR-1:0] dir;
    logic             failsafe_en;
    logic             wkup;
  } pin_snap_t;
endpackage

// File: rtl/sst_sync.sv
module sst_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= RST_VAL;
      else        chain <= d;
    end
  end else begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-W-1:0], d};
    end
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/sst_edge.sv
module sst_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= cur;
  end

  assign rise = ~prev & cur;
  assign fall = prev & ~cur;
endmodule

// File: rtl/sst_word_mux.sv
module sst_word_mux
  import sst_pkg::*;
#(
  parameter int N_LS = 8,
  parameter int N_HS = 4,
  localparam int WORD_W = CTRL_BITS + N_LS + N_HS
) (
  input  logic              echo,
  input  pin_snap_t         pins,
  input  logic [N_LS-1:0]   ls_flt,
  input  logic [N_HS-1:0]   hs_flt,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word              = '0;
    word[WORD_W-1]    = echo;
    word[WORD_W-2]    = echo ? pins.dir[2] : pins.dir[0];
    word[WORD_W-3]    = echo ? pins.dir[3] : pins.dir[1];
    word[WORD_W-4]    = echo ? pins.wkup   : pins.failsafe_en;
    word[N_HS +: N_LS] = ls_flt;
    word[0 +: N_HS]    = hs_flt;
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi_s,
  input  logic [WORD_W-1:0] load_word,
  output logic              active,
  output logic [WORD_W-1:0] shreg,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              wd_echo,
  output logic              sdo
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] rxreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      shreg   <= '0;
      rxreg   <= '0;
      bit_cnt <= '0;
      wd_echo <= 1'b0;
    end else if (sel_fall) begin
      active  <= 1'b1;
      shreg   <= load_word;
      bit_cnt <= '0;
    end else if (active) begin
      if (sel_rise) begin
        active <= 1'b0;
        if (bit_cnt == CNT_FULL) wd_echo <= rxreg[WORD_W-1];
      end else begin
        if (sck_rise) begin
          rxreg <= {rxreg[WORD_W-2:0], sdi_s};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall) shreg <= {shreg[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign sdo = active & shreg[WORD_W-1];
endmodule

// File: rtl/spi_status_word.sv
module spi_status_word
  import sst_pkg::*;
#(
  parameter int N_LS        = 8,
  parameter int N_HS        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             wd_echo,
  input  logic [N_DIR-1:0] dir_in,
  input  logic             failsafe_en,
  input  logic             wkup_lvl,
  input  logic [N_LS-1:0]  ls_flt,
  input  logic [N_HS-1:0]  hs_flt
);
  localparam int WORD_W = CTRL_BITS + N_LS + N_HS;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  // Pin order inside the synchronizer: {select, clock, data}
  logic [2:0] pins_s;
  logic       sel_s, sck_s, sdi_s;
  logic [1:0] e_rise, e_fall;
  logic       cs_rise, cs_fall, sck_rise, sck_fall;
  logic       active;
  logic [WORD_W-1:0] shreg, load_word;
  logic [CNT_W-1:0]  bit_cnt;
  pin_snap_t         snap;

  sst_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_n, sck, sdi}), .q(pins_s)
  );

  assign {sel_s, sck_s, sdi_s} = pins_s;

  sst_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur({sel_s, sck_s}), .rise(e_rise), .fall(e_fall)
  );

  // Select is active low: a rising select level ends a frame
  assign cs_rise  = e_rise[1];
  assign cs_fall  = e_fall[1];
  assign sck_rise = e_rise[0];
  assign sck_fall = e_fall[0];

  assign snap = '{dir: dir_in, failsafe_en: failsafe_en, wkup: wkup_lvl};

  sst_word_mux #(.N_LS(N_LS), .N_HS(N_HS)) u_mux (
    .echo(wd_echo), .pins(snap), .ls_flt(ls_flt), .hs_flt(hs_flt), .word(load_word)
  );

  sst_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_fall(cs_fall), .sel_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi_s(sdi_s), .load_word(load_word),
    .active(active), .shreg(shreg), .bit_cnt(bit_cnt),
    .wd_echo(wd_echo), .sdo(sdo)
  );
endmodule

// File: rtl/spi_status_word_chk.sv
module spi_status_word_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic              sdo,
  input logic              wd_echo,
  input logic              cs_rise,
  input logic              sck_fall,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [WORD_W-1:0] shreg
);
  assert_quiet_after_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise) |-> !sdo);

  assert_first_bit_is_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> shreg[WORD_W-1] == wd_echo);

  assert_echo_only_on_full_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wd_echo) |-> ($past(cs_rise) && $past(bit_cnt) == CNT_W'(WORD_W)));

  assert_count_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W + 1));

  assert_word_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(sck_fall)) |-> $stable(shreg));
endmodule

bind spi_status_word spi_status_word_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .sdo(sdo), .wd_echo(wd_echo),
  .cs_rise(cs_rise), .sck_fall(sck_fall), .bit_cnt(bit_cnt), .shreg(shreg)
);

// File: tb/spi_status_word_tb.sv
module spi_status_word_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       sel_n = 1, sck = 0, sdi = 0;
  logic       sdo, wd_echo;
  logic [3:0] dir_in = '0;
  logic       failsafe_en = 0, wkup_lvl = 0;
  logic [7:0] ls_flt = '0;
  logic [3:0] hs_flt = '0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  spi_status_word u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .wd_echo(wd_echo), .dir_in(dir_in), .failsafe_en(failsafe_en),
    .wkup_lvl(wkup_lvl), .ls_flt(ls_flt), .hs_flt(hs_flt)
  );

  // {tx[15:0], dir[3:0], strap, wake, ls[7:0], hs[3:0], expected reply[15:0]}
  localparam int NV = 6;
  localparam logic [49:0] VEC [NV] = '{
    {16'h8000, 4'b0101, 1'b1, 1'b0, 8'hA5, 4'h3, 16'h5A53},
    {16'h0000, 4'b1001, 1'b0, 1'b1, 8'h3C, 4'hC, 16'hB3CC},
    {16'hFFFF, 4'b1110, 1'b0, 1'b1, 8'hFF, 4'h0, 16'h2FF0},
    {16'h7FFF, 4'b0100, 1'b1, 1'b0, 8'h00, 4'hF, 16'hC00F},
    {16'h1234, 4'b0011, 1'b0, 1'b1, 8'h81, 4'h5, 16'h6815},
    {16'h8000, 4'b0000, 1'b1, 1'b1, 8'h42, 4'hA, 16'h142A}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_pins(input logic [3:0] d, input logic fs, input logic wk,
                          input logic [7:0] ls, input logic [3:0] hs);
    dir_in = d; failsafe_en = fs; wkup_lvl = wk; ls_flt = ls; hs_flt = hs;
  endtask

  // nbits clocks; poke inverts all status inputs just after the first rising sck
  task automatic xfer(input logic [15:0] tx, input int nbits, input bit poke,
                      output logic [15:0] got);
    got = '0;
    @(negedge clk) sel_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? tx[15-i] : 1'b0;
      repeat (4) @(negedge clk);
      if (i < 16) got[15-i] = sdo;
      sck = 1;
      if (poke && i == 0) begin
        dir_in = ~dir_in; failsafe_en = ~failsafe_en; wkup_lvl = ~wkup_lvl;
        ls_flt = ~ls_flt; hs_flt = ~hs_flt;
      end
      repeat (4) @(negedge clk);
      sck = 0;
    end
    repeat (4) @(negedge clk);
    sel_n = 1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk);
    check(wd_echo == 1'b0, "R1 echo at reset", {15'd0, wd_echo}, 16'h0);
    check(sdo == 1'b0, "R1 sdo at reset", {15'd0, sdo}, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // Table walk: each reply depends on the previous vector's bit 15
    for (int v = 0; v < NV; v++) begin
      set_pins(VEC[v][33:30], VEC[v][29], VEC[v][28], VEC[v][27:20], VEC[v][19:16]);
      xfer(VEC[v][49:34], 16, 1'b0, got);
      check(got == VEC[v][15:0], "R3/R4/R5/R6 reply word", got, VEC[v][15:0]);
      check(wd_echo == VEC[v][49], "R7 echo after full frame", {15'd0, wd_echo},
            {15'd0, VEC[v][49]});
      check(sdo == 1'b0, "R2 sdo deselected", {15'd0, sdo}, 16'h0);
    end

    // Short frame: echo (1) must survive a cleared bit 15
    set_pins(4'h0, 1'b0, 1'b0, 8'h00, 4'h0);
    xfer(16'h0000, 8, 1'b0, got);
    check(wd_echo == 1'b1, "R7 short frame ignored", {15'd0, wd_echo}, 16'h1);
    xfer(16'h0000, 16, 1'b0, got);
    check(got == 16'h8000, "R7 reply after short frame", got, 16'h8000);
    check(wd_echo == 1'b0, "R7 full frame commits", {15'd0, wd_echo}, 16'h0);

    // Long frame: echo (0) must survive a set bit 15
    xfer(16'hFFFF, 17, 1'b0, got);
    check(wd_echo == 1'b0, "R7 long frame ignored", {15'd0, wd_echo}, 16'h0);
    xfer(16'h0000, 16, 1'b0, got);
    check(got == 16'h0000, "R7 reply after long frame", got, 16'h0000);

    // Snapshot: inputs flip mid-frame, reply must not
    set_pins(4'b0001, 1'b0, 1'b0, 8'h11, 4'h9);
    xfer(16'h0000, 16, 1'b1, got);
    check(got == 16'h4119, "R8 word frozen at select", got, 16'h4119);

    // Reset clears a set echo
    xfer(16'h8000, 16, 1'b0, got);
    check(wd_echo == 1'b1, "R7 echo set before reset", {15'd0, wd_echo}, 16'h1);
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    check(wd_echo == 1'b0, "R1 echo cleared by reset", {15'd0, wd_echo}, 16'h0);
    check(sdo == 1'b0, "R1 sdo low in reset", {15'd0, sdo}, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    set_pins(4'h0, 1'b0, 1'b0, 8'h00, 4'h0);
    xfer(16'h0000, 16, 1'b0, got);
    check(got == 16'h0000, "R3 echo 0 after reset", got, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule